// File: doc/BRIEF.md
# Multi-Format Synchronous Serial Master Port

This block is a full-duplex serial master that sits on a simple register bus. A single data address is split by direction: a bus write pushes a word into a 16-entry transmit queue, and a bus read pops the oldest word from a 16-entry receive queue. Both queues hold 16-bit words. A serial engine takes words from the transmit queue, shifts them out MSB first on a data-out line while it samples the data-in line into a parallel word, and generates the serial clock and the frame signal itself, because the peripheral is always the slave.

Three frame styles share one engine: an SPI-style frame with an active-low select held across the word, a pulse-framed style where a one-clock-period frame pulse precedes the word, and a half-duplex command/response style where an 8-bit command goes out first and a response of the programmed length is then captured. Word length runs from 4 to 16 bits and the serial clock comes from a programmable divider of the system clock. An interrupt output is raised while the receive queue holds more words than a programmed level, if enabled.

Top module: `smp_port`

## Requirements
- R1: After reset the status word (address 2) reads 0x1 (only transmit-not-full set), the control word (address 1) reads 0x7, the serial clock is low, the frame line is high and the interrupt is low.
- R2: A write to address 0 pushes bits [15:0] of the bus word into the transmit queue; bits [31:16] have no effect on the serial data.
- R3: In SPI-style format (control bits [5:4] = 0) the frame line is low for the whole word, the serial clock idles low, data-out changes only on falling clock edges, data-in is sampled on rising edges, bits go MSB first and the received word is right-justified with zeros above.
- R4: Control bits [3:0] hold word length minus one; only the low N bits of a transmit word are sent; a field value below 3 acts as 3 (4-bit words).
- R5: In pulse-framed format (control bits [5:4] = 1) the frame line is high for exactly one serial clock period immediately before the word and low during it.
- R6: In command/response format (control bits [5:4] = 2) the frame line is low for the whole frame, bits [7:0] of the transmit word go out MSB first, then N further clocks run with data-out low, and the last N sampled bits form the received word.
- R7: The serial clock period is 2*(D+1) system clock cycles, where D is control bits [23:16].
- R8: A read of address 0 pops the receive queue; when it is empty the read returns 0 and sets the sticky underrun flag (status bit 5).
- R9: A write to address 0 while the transmit queue is full is dropped and sets the sticky overflow flag (status bit 4).
- R10: A word completing while the receive queue is full is dropped and sets the sticky overrun flag (status bit 6).
- R11: The interrupt output and status bit 3 are high exactly when the enable (control bit 6) is set and the receive count exceeds the level in control bits [11:8].
- R12: Writing address 2 with a 1 in bit 4, 5 or 6 clears that sticky flag.
- R13: Status bit 2 (busy) is high while a frame runs or transmit words wait; frames follow each other while the transmit queue is not empty, so consecutive writes are sent in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | 2 | Register address: 0 data, 1 control, 2 status |
| wdata | input | 32 | Bus write data |
| rdata | output | 32 | Bus read data, valid in the strobe cycle |
| irq_o | output | 1 | Receive-level interrupt |
| sclk_o | output | 1 | Serial clock to the peripheral |
| txd_o | output | 1 | Serial data out |
| rxd_i | input | 1 | Serial data in |
| frm_o | output | 1 | Frame line: select (active low) or frame pulse (active high) |

## Verification
The transmit queue can be pushed by the bus and popped by the engine in the same cycle. Two words are written on consecutive cycles so that the second push lands on the edge where the engine takes the first word out; the bench then demands that both words appear on the serial line in order and come back through the loopback in order. A long burst into a slow engine also pushes past full and past receive-full, and the dropped words, the sticky flags and the interrupt level are judged from the status word and the read data.

// File: rtl/smp_pkg.sv
package smp_pkg;
  typedef enum logic [1:0] {
    FMT_SEL   = 2'd0,
    FMT_PULSE = 2'd1,
    FMT_CMD   = 2'd2
  } fmt_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_DATA = 2'd2
  } eng_st_e;

  localparam int ADR_DATA = 0;
  localparam int ADR_CTRL = 1;
  localparam int ADR_STAT = 2;

  localparam int CF_WLEN = 0;
  localparam int CF_FMT  = 4;
  localparam int CF_IEN  = 6;
  localparam int CF_THR  = 8;
  localparam int CF_DIV  = 16;

  localparam int SB_TXNF = 0;
  localparam int SB_RXNE = 1;
  localparam int SB_BUSY = 2;
  localparam int SB_IRQ  = 3;
  localparam int SB_OVF  = 4;
  localparam int SB_UNF  = 5;
  localparam int SB_ORUN = 6;
endpackage

// File: rtl/smp_fifo.sv
module smp_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic                       pop,
  input  logic [W-1:0]               din,
  output logic [W-1:0]               dout,
  output logic                       full,
  output logic                       empty,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0] mem [DEPTH];
  logic [PW:0]  wp_q, rp_q, wp_d, rp_d;

  always_comb begin
    wp_d = push ? wp_q + 1'b1 : wp_q;
    rp_d = pop  ? rp_q + 1'b1 : rp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      wp_q <= wp_d;
      rp_q <= rp_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q[PW-1:0]] <= din;
  end

  assign count = CW'(wp_q - rp_q);
  assign empty = (wp_q == rp_q);
  assign full  = (wp_q[PW] != rp_q[PW]) && (wp_q[PW-1:0] == rp_q[PW-1:0]);
  assign dout  = mem[rp_q[PW-1:0]];
endmodule

// File: rtl/smp_baud.sv
module smp_baud #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [DIVW-1:0] div,
  output logic            tick
);
  logic [DIVW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = run && (cnt_q == div);
    cnt_d = (!run || tick) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/smp_engine.sv
module smp_engine
  import smp_pkg::*;
#(
  parameter int DW   = 16,
  parameter int CMDW = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic                  tx_avail,
  input  logic [DW-1:0]         tx_word,
  output logic                  tx_pop,
  input  fmt_e                  fmt_i,
  input  logic [$clog2(DW)-1:0] nm1_i,
  input  logic                  rxd_i,
  output logic                  rx_push,
  output logic [DW-1:0]         rx_word,
  output logic                  sclk_o,
  output logic                  txd_o,
  output logic                  frm_o,
  output logic                  active_o
);
  localparam int LW = $clog2(DW);
  localparam int CW = $clog2(DW + CMDW + 1);
  localparam logic [LW-1:0] TOPB = LW'(DW - 1);

  eng_st_e       st_q, st_d;
  fmt_e          fmt_q, fmt_d;
  logic [LW-1:0] nm1_q, nm1_d;
  logic          ph_q, ph_d, sclk_q, sclk_d;
  logic [DW-1:0] txs_q, txs_d, rxs_q, rxs_d;
  logic [CW-1:0] left_q, left_d;

  always_comb begin
    st_d = st_q; fmt_d = fmt_q; nm1_d = nm1_q; ph_d = ph_q; sclk_d = sclk_q;
    txs_d = txs_q; rxs_d = rxs_q; left_d = left_q;
    tx_pop = 1'b0;
    rx_push = 1'b0;
    if (st_q == ST_IDLE) begin
      if (tx_avail) begin
        tx_pop = 1'b1;
        fmt_d  = fmt_i;
        nm1_d  = nm1_i;
        rxs_d  = '0;
        ph_d   = 1'b0;
        sclk_d = 1'b0;
        if (fmt_i == FMT_CMD) begin
          txs_d  = {tx_word[CMDW-1:0], {(DW-CMDW){1'b0}}};
          left_d = CW'(CMDW) + CW'(nm1_i) + CW'(1);
        end else begin
          txs_d  = tx_word << (TOPB - nm1_i);
          left_d = CW'(nm1_i) + CW'(1);
        end
        st_d = (fmt_i == FMT_PULSE) ? ST_PRE : ST_DATA;
      end
    end else if (tick) begin
      if (!ph_q) begin
        sclk_d = 1'b1;
        ph_d   = 1'b1;
        if (st_q == ST_DATA) rxs_d = {rxs_q[DW-2:0], rxd_i};
      end else begin
        sclk_d = 1'b0;
        ph_d   = 1'b0;
        if (st_q == ST_PRE) begin
          st_d = ST_DATA;
        end else begin
          txs_d  = txs_q << 1;
          left_d = left_q - 1'b1;
          if (left_q == CW'(1)) begin
            st_d    = ST_IDLE;
            rx_push = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      fmt_q  <= FMT_SEL;
      nm1_q  <= '0;
      ph_q   <= 1'b0;
      sclk_q <= 1'b0;
      txs_q  <= '0;
      rxs_q  <= '0;
      left_q <= '0;
    end else begin
      st_q   <= st_d;
      fmt_q  <= fmt_d;
      nm1_q  <= nm1_d;
      ph_q   <= ph_d;
      sclk_q <= sclk_d;
      txs_q  <= txs_d;
      rxs_q  <= rxs_d;
      left_q <= left_d;
    end
  end

  // keep the last N sampled bits, zeros above
  assign rx_word  = rxs_q & ~(({DW{1'b1}} << nm1_q) << 1);
  assign sclk_o   = sclk_q;
  assign txd_o    = (st_q != ST_IDLE) && txs_q[DW-1];
  assign active_o = (st_q != ST_IDLE);
  assign frm_o    = (st_q == ST_IDLE) ? (fmt_i != FMT_PULSE)
                  : (fmt_q == FMT_PULSE) && (st_q == ST_PRE);
endmodule

// File: rtl/smp_port.sv
module smp_port
  import smp_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  parameter int DIVW  = 8,
  parameter int BW    = 32,
  parameter int AW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [BW-1:0] wdata,
  output logic [BW-1:0] rdata,
  output logic          irq_o,
  output logic          sclk_o,
  output logic          txd_o,
  input  logic          rxd_i,
  output logic          frm_o
);
  localparam int LW   = $clog2(DW);
  localparam int TW   = $clog2(DEPTH);
  localparam int CNTW = $clog2(DEPTH+1);
  localparam logic [LW-1:0] MIN_NM1 = LW'(3);

  logic [LW-1:0]   wlen_q, wlen_d, wlen_eff;
  fmt_e            fmt_q, fmt_d;
  logic            ien_q, ien_d;
  logic [TW-1:0]   thr_q, thr_d;
  logic [DIVW-1:0] div_q, div_d;
  logic            ovf_q, ovf_d, unf_q, unf_d, orun_q, orun_d;

  logic            wr_data, rd_data, wr_ctrl, wr_stat;
  logic            tx_push, tx_pop, tx_full, tx_empty;
  logic            rx_push_eng, rx_push, rx_pop, rx_full, rx_empty;
  logic [DW-1:0]   tx_head, rx_head, rx_word;
  logic [CNTW-1:0] tx_cnt, rx_cnt;
  logic            tick, eng_active, irq;
  logic            unused_hi;

  assign wr_data = wr_en && (addr == AW'(ADR_DATA));
  assign wr_ctrl = wr_en && (addr == AW'(ADR_CTRL));
  assign wr_stat = wr_en && (addr == AW'(ADR_STAT));
  assign rd_data = rd_en && (addr == AW'(ADR_DATA));

  assign tx_push = wr_data && !tx_full;
  assign rx_push = rx_push_eng && !rx_full;
  assign rx_pop  = rd_data && !rx_empty;
  assign wlen_eff = (wlen_q < MIN_NM1) ? MIN_NM1 : wlen_q;
  assign irq = ien_q && (rx_cnt > CNTW'(thr_q));
  assign unused_hi = ^wdata[BW-1:CF_DIV+DIVW];

  always_comb begin
    wlen_d = wlen_q; fmt_d = fmt_q; ien_d = ien_q; thr_d = thr_q; div_d = div_q;
    if (wr_ctrl) begin
      wlen_d = wdata[CF_WLEN +: LW];
      fmt_d  = fmt_e'(wdata[CF_FMT +: 2]);
      ien_d  = wdata[CF_IEN];
      thr_d  = wdata[CF_THR +: TW];
      div_d  = wdata[CF_DIV +: DIVW];
    end
    ovf_d  = (ovf_q  && !(wr_stat && wdata[SB_OVF]))  || (wr_data && tx_full);
    unf_d  = (unf_q  && !(wr_stat && wdata[SB_UNF]))  || (rd_data && rx_empty);
    orun_d = (orun_q && !(wr_stat && wdata[SB_ORUN])) || (rx_push_eng && rx_full);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wlen_q <= LW'(7);
      fmt_q  <= FMT_SEL;
      ien_q  <= 1'b0;
      thr_q  <= '0;
      div_q  <= '0;
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
      orun_q <= 1'b0;
    end else begin
      wlen_q <= wlen_d;
      fmt_q  <= fmt_d;
      ien_q  <= ien_d;
      thr_q  <= thr_d;
      div_q  <= div_d;
      ovf_q  <= ovf_d;
      unf_q  <= unf_d;
      orun_q <= orun_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      AW'(ADR_DATA): if (!rx_empty) rdata[DW-1:0] = rx_head;
      AW'(ADR_CTRL): begin
        rdata[CF_WLEN +: LW]  = wlen_q;
        rdata[CF_FMT +: 2]    = fmt_q;
        rdata[CF_IEN]         = ien_q;
        rdata[CF_THR +: TW]   = thr_q;
        rdata[CF_DIV +: DIVW] = div_q;
      end
      AW'(ADR_STAT): begin
        rdata[SB_TXNF] = !tx_full;
        rdata[SB_RXNE] = !rx_empty;
        rdata[SB_BUSY] = eng_active || !tx_empty;
        rdata[SB_IRQ]  = irq;
        rdata[SB_OVF]  = ovf_q;
        rdata[SB_UNF]  = unf_q;
        rdata[SB_ORUN] = orun_q;
      end
      default: rdata = '0;
    endcase
  end

  assign irq_o = irq;

  smp_fifo #(.W(DW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .pop(tx_pop), .din(wdata[DW-1:0]),
    .dout(tx_head), .full(tx_full), .empty(tx_empty), .count(tx_cnt)
  );

  smp_fifo #(.W(DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .pop(rx_pop), .din(rx_word),
    .dout(rx_head), .full(rx_full), .empty(rx_empty), .count(rx_cnt)
  );

  smp_baud #(.DIVW(DIVW)) u_baud (
    .clk(clk), .rst_n(rst_n), .run(eng_active), .div(div_q), .tick(tick)
  );

  smp_engine #(.DW(DW), .CMDW(8)) u_eng (
    .clk(clk), .rst_n(rst_n), .tick(tick), .tx_avail(!tx_empty), .tx_word(tx_head),
    .tx_pop(tx_pop), .fmt_i(fmt_q), .nm1_i(wlen_eff), .rxd_i(rxd_i),
    .rx_push(rx_push_eng), .rx_word(rx_word), .sclk_o(sclk_o), .txd_o(txd_o),
    .frm_o(frm_o), .active_o(eng_active)
  );
endmodule

// File: rtl/smp_port_chk.sv
module smp_port_chk #(
  parameter int BW   = 32,
  parameter int AW   = 2,
  parameter int CNTW = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic            rd_en,
  input logic [AW-1:0]   addr,
  input logic [BW-1:0]   rdata,
  input logic            irq_o,
  input logic            sclk_o,
  input logic            txd_o,
  input logic            tx_full,
  input logic            tx_pop,
  input logic [CNTW-1:0] tx_cnt,
  input logic            rx_empty,
  input logic            rx_full,
  input logic            orun_q
);
  a_r3_txd_still_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_o) |-> $stable(txd_o));

  a_r8_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == '0 && rx_empty) |-> (rdata == '0));

  a_r9_full_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == '0 && tx_full && !tx_pop) |=> (tx_cnt == $past(tx_cnt)));

  a_r10_overrun_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(orun_q) |-> $past(rx_full));

  a_r11_irq_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> !rx_empty);
endmodule

bind smp_port smp_port_chk #(.BW(BW), .AW(AW), .CNTW(CNTW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .rdata(rdata), .irq_o(irq_o), .sclk_o(sclk_o), .txd_o(txd_o),
  .tx_full(tx_full), .tx_pop(tx_pop), .tx_cnt(tx_cnt),
  .rx_empty(rx_empty), .rx_full(rx_full), .orun_q(orun_q)
);

// File: tb/smp_port_tb.sv
module smp_port_tb;
  logic        clk, rst_n, wr_en, rd_en, inv;
  logic [1:0]  addr;
  logic [31:0] wdata, rdata;
  logic        irq_o, sclk_o, txd_o, rxd_i, frm_o;

  int n_run, n_fail;

  // capture state, owned by the negedge monitor
  logic [31:0] cap;
  int          capn, npre, per, since, clr_gen, seen_gen;
  logic        sclk_prev;

  smp_port u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_o(irq_o), .sclk_o(sclk_o),
    .txd_o(txd_o), .rxd_i(rxd_i), .frm_o(frm_o)
  );

  assign rxd_i = txd_o ^ inv;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(negedge clk) begin
    sclk_prev <= sclk_o;
    if (clr_gen != seen_gen) begin
      seen_gen <= clr_gen;
      cap <= '0; capn <= 0; npre <= 0;
    end else if (sclk_o && !sclk_prev) begin
      if (frm_o) npre <= npre + 1;
      else begin cap <= {cap[30:0], txd_o}; capn <= capn + 1; end
    end
    if (sclk_o && !sclk_prev) begin per <= since; since <= 1; end
    else since <= since + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic wr_seq(input int n, input logic [31:0] base, input logic [31:0] step);
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      addr = 2'd0; wdata = base + i * step; wr_en = 1'b1;
      @(negedge clk);
    end
    wr_en = 1'b0;
  endtask

  task automatic cfg(input int nm1, input int fmt, input bit ien, input int thr, input int dv);
    wr(2'd1, (dv << 16) | (thr << 8) | (int'(ien) << 6) | (fmt << 4) | nm1);
  endtask

  task automatic clr_cap();
    clr_gen++;
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    do rd(2'd2, s); while (s[2]);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(2'd2, v); check("R1 status", v, 32'h1);
    rd(2'd1, v); check("R1 control", v, 32'h7);
    check("R1 lines", {29'd0, sclk_o, frm_o, irq_o}, 32'h2);
  endtask

  task automatic t_spi();
    logic [31:0] v;
    inv = 1'b1; cfg(11, 0, 0, 0, 1); clr_cap();
    wr(2'd0, 32'hDEAD_5ABC); wait_idle();
    check("R2 R3 sent bits", cap, 32'hABC);
    check("R4 bit count", capn, 12);
    check("R3 no pulse", npre, 0);
    rd(2'd0, v); check("R3 received right-justified", v, 32'h543);
  endtask

  task automatic t_len();
    logic [31:0] v;
    inv = 1'b0;
    cfg(15, 0, 0, 0, 0); clr_cap(); wr(2'd0, 32'hFFFF_8001); wait_idle();
    check("R4 16-bit sent", cap, 32'h8001);
    rd(2'd0, v); check("R4 16-bit loop", v, 32'h8001);
    cfg(1, 0, 0, 0, 0); clr_cap(); wr(2'd0, 32'h0000_00F6); wait_idle();
    check("R4 short field gives 4 bits", capn, 4);
    check("R4 short field data", cap, 32'h6);
    rd(2'd0, v); check("R4 4-bit loop", v, 32'h6);
  endtask

  task automatic t_pulse();
    logic [31:0] v;
    inv = 1'b0; cfg(7, 1, 0, 0, 2); clr_cap();
    wr(2'd0, 32'h0000_00A5); wait_idle();
    check("R5 one pulse clock", npre, 1);
    check("R5 data", cap, 32'hA5);
    rd(2'd0, v); check("R5 loop", v, 32'hA5);
  endtask

  task automatic t_cmd();
    logic [31:0] v;
    inv = 1'b1; cfg(7, 2, 0, 0, 1); clr_cap();
    wr(2'd0, 32'h0000_1234); wait_idle();
    check("R6 clocks", capn, 16);
    check("R6 command then low", cap, 32'h3400);
    check("R6 select held", npre, 0);
    rd(2'd0, v); check("R6 response", v, 32'hFF);
  endtask

  task automatic t_rate();
    logic [31:0] v;
    inv = 1'b0;
    cfg(7, 0, 0, 0, 3); wr(2'd0, 32'h55); wait_idle();
    check("R7 period div 3", per, 8);
    rd(2'd0, v);
    cfg(7, 0, 0, 0, 0); wr(2'd0, 32'h55); wait_idle();
    check("R7 period div 0", per, 2);
    rd(2'd0, v);
  endtask

  task automatic t_b2b();
    logic [31:0] v;
    inv = 1'b0; cfg(7, 0, 0, 0, 1); clr_cap();
    wr_seq(2, 32'h11, 32'h11); wait_idle();
    check("R13 both words in order", cap, 32'h1122);
    rd(2'd0, v); check("R13 first back", v, 32'h11);
    rd(2'd0, v); check("R13 second back", v, 32'h22);
  endtask

  task automatic t_full();
    logic [31:0] v;
    inv = 1'b0; cfg(3, 0, 1, 5, 255);
    wr_seq(18, 32'h0, 32'h1);
    rd(2'd2, v); check("R9 overflow while busy", v & 32'h14, 32'h14);
    wait_idle();
    rd(2'd2, v); check("R10 R11 status full", v, 32'h5B);
    check("R11 irq high", irq_o, 1'b1);
    cfg(3, 0, 0, 5, 255);
    check("R11 irq disabled", irq_o, 1'b0);
    cfg(3, 0, 1, 5, 255);
    for (int i = 0; i < 16; i++) begin
      rd(2'd0, v);
      if (i < 3 || i == 15) check("R8 R10 pop order", v, i);
      if (i == 9)  check("R11 count 6 above 5", irq_o, 1'b1);
      if (i == 10) check("R11 count 5 not above", irq_o, 1'b0);
    end
    rd(2'd0, v); check("R8 empty read", v, 32'h0);
    rd(2'd2, v); check("R8 underrun status", v, 32'h71);
    wr(2'd2, 32'h70);
    rd(2'd2, v); check("R12 flags cleared", v, 32'h01);
  endtask

  initial begin
    n_run = 0; n_fail = 0;
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    clr_gen = 0; seen_gen = 0; cap = '0; capn = 0; npre = 0; per = 0; since = 0;
    sclk_prev = 1'b0;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0; inv = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_spi();
    t_len();
    t_pulse();
    t_cmd();
    t_rate();
    t_b2b();
    t_full();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule